// File: doc/BRIEF.md
# Six-Output Steered PWM Generator

This block produces one pulse-width-modulated waveform from a timer counter and routes it to six output pins arranged as three complementary pairs. The counter advances on each cycle where the timer tick is high. It runs either as a sawtooth (count up, then wrap to zero) or as a triangle (count up to the period limit, then back down to zero). A compare value sets the duty. A two-bit output mode either disconnects the waveform from the pins or connects it in normal or inverted polarity.

Each pin has its own enable bit. A pin whose enable bit is low, or any pin while the output mode is disconnected, shows a software-supplied port value instead of the waveform. The period limit, the compare value and the slope selection are double-buffered. Values written at any time take effect only at the reload point, so a period is never cut short or stretched. A sticky overflow flag marks each reload point. A one-cycle clear input resets the flag.

No data stream crosses this block, so there is no valid/ready handshake. Every input is a level-sampled control register and every output is a plain status or pin level.

Top module: `pwm6_steer`

## Requirements
- R1: In sawtooth mode (slope_dual = 0 in the active set) the counter goes 0, 1, … up to the active period limit. On the tick after it equals the limit it returns to 0, so one period lasts limit + 1 ticks.
- R2: In triangle mode (slope_dual = 1 in the active set) the counter goes 0 up to the limit and then back down to 0, so one period lasts 2 × limit ticks. With a limit of 0 the counter stays at 0.
- R3: The counter, the direction and the waveform change only on clock edges where tick is 1. With tick at 0, the pins and the flag hold their values, except that the flag can still be cleared.
- R4: ovf_flag is set on the tick that takes the counter to 0 by a reload. That is the wrap from the limit in sawtooth mode, and the arrival at zero while counting down in triangle mode. The flag stays set until a cycle with ovf_clr = 1 and no reload. When a reload and a clear fall on the same tick, the flag is set.
- R5: In sawtooth mode the raw waveform is 1 while count < compare. A compare value of 0 gives a waveform that is always 0. A compare value above the limit gives a waveform that is always 1.
- R6: In triangle mode the raw waveform goes to 0 at the compare match while counting up and returns to 1 at the match while counting down. It is therefore 1 while count < compare on the way up, and while count ≤ compare on the way down. The counter is still treated as counting up while it sits at the limit.
- R7: out_mode encoding: 2'b00 disconnects the waveform from all pins. 2'b01 and 2'b10 connect it non-inverted. 2'b11 connects the inverted raw waveform. The output mode takes effect at once and is not buffered.
- R8: Pins 0, 2 and 4 carry the connected waveform. Pins 1, 3 and 5 carry its complement.
- R9: Pin i shows port_val[i] whenever pin_en[i] = 0 or out_mode = 2'b00. Otherwise it shows the pin's waveform.
- R10: period_lim, cmp_val and slope_dual are captured on every reload tick, including the first tick after reset (the reset state has a limit of 0, so the first tick is a reload). A write between reloads has no effect until the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer advance enable |
| period_lim | input | CNT_W | Period limit (TOP), buffered |
| cmp_val | input | CNT_W | Compare value, buffered |
| slope_dual | input | 1 | 0 sawtooth, 1 triangle, buffered |
| out_mode | input | 2 | Waveform connection/polarity |
| pin_en | input | 2*NUM_PAIRS | Per-pin waveform enable |
| port_val | input | 2*NUM_PAIRS | Per-pin fallback level |
| pins | output | 2*NUM_PAIRS | Output pin levels |
| ovf_flag | output | 1 | Sticky reload flag |
| ovf_clr | input | 1 | One-cycle flag clear |

## Verification
The hardest case to reach is a flag clear that lands on the same tick as a reload, together with register writes that arrive mid-period and must stay invisible until the reload. The sweeps hold the clear input high throughout, so every reload tick is a set-against-clear collision, and the flag must then read exactly at the reload positions. A dedicated sequence writes a new limit, compare value and slope partway through a sawtooth period. It then checks that the old pattern completes and that the triangle pattern starts exactly at the wrap.

// File: rtl/pwm6_pkg.sv
package pwm6_pkg;
  typedef enum logic [1:0] {
    OUT_OFF    = 2'b00,
    OUT_NORM_A = 2'b01,
    OUT_NORM   = 2'b10,
    OUT_INV    = 2'b11
  } out_mode_e;
endpackage

// File: rtl/pwm6_counter.sv
module pwm6_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] period_lim,
  input  logic             slope_dual,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_up,
  output logic             mode_act,
  output logic             reload
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] lim_act;
  logic [CNT_W-1:0] cnt_nxt;
  logic             dir_nxt;
  logic             wrap;

  always_comb begin
    cnt_nxt = cnt;
    dir_nxt = dir_up;
    wrap    = 1'b0;
    if (!mode_act) begin
      dir_nxt = 1'b1;
      if (cnt == lim_act) begin
        cnt_nxt = '0;
        wrap    = 1'b1;
      end else begin
        cnt_nxt = cnt + ONE;
      end
    end else if (dir_up && cnt != lim_act) begin
      cnt_nxt = cnt + ONE;
    end else if (cnt <= ONE) begin
      cnt_nxt = '0;
      dir_nxt = 1'b1;
      wrap    = 1'b1;
    end else begin
      cnt_nxt = cnt - ONE;
      dir_nxt = 1'b0;
    end
  end

  assign reload = tick & wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      dir_up   <= 1'b1;
      lim_act  <= '0;
      mode_act <= 1'b0;
    end else if (tick) begin
      cnt    <= cnt_nxt;
      dir_up <= dir_nxt;
      if (wrap) begin
        lim_act  <= period_lim;
        mode_act <= slope_dual;
      end
    end
  end

  assert_cnt_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim_act);
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt) && $stable(dir_up));
  assert_turn_at_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dir_up) |-> $past(cnt) == $past(lim_act));
  assert_limit_buffered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> $stable(lim_act) && $stable(mode_act));
endmodule

// File: rtl/pwm6_wave.sv
module pwm6_wave
  import pwm6_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dir_up,
  input  logic             mode_act,
  input  logic [1:0]       out_mode,
  output logic             wave
);
  logic [CNT_W-1:0] cmp_act;
  logic             raw;

  always_ff @(posedge clk) begin
    if (!rst_n)      cmp_act <= '0;
    else if (reload) cmp_act <= cmp_val;
  end

  assign raw  = (cnt < cmp_act) || (mode_act && !dir_up && cnt == cmp_act);
  assign wave = (out_mode_e'(out_mode) == OUT_INV) ? ~raw : raw;

  assert_cmp_buffered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> $stable(cmp_act));
  assert_down_match_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act && !dir_up && cnt == cmp_act && out_mode != 2'b11) |-> wave);
endmodule

// File: rtl/pwm6_pinmux.sv
module pwm6_pinmux
  import pwm6_pkg::*;
#(
  parameter int NUM_PAIRS = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wave,
  input  logic [1:0]             out_mode,
  input  logic [2*NUM_PAIRS-1:0] pin_en,
  input  logic [2*NUM_PAIRS-1:0] port_val,
  output logic [2*NUM_PAIRS-1:0] pins
);
  localparam int NPIN = 2 * NUM_PAIRS;

  logic             connected;
  logic [NPIN-1:0]  gen;

  assign connected = (out_mode_e'(out_mode) != OUT_OFF);

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    assign gen[2*k]   = wave;
    assign gen[2*k+1] = ~wave;

    assert_pair_invert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (connected && pin_en[2*k] && pin_en[2*k+1]) |-> pins[2*k] != pins[2*k+1]);
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign pins[i] = (connected && pin_en[i]) ? gen[i] : port_val[i];
  end

  assert_port_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode == 2'b00) |-> pins == port_val);
endmodule

// File: rtl/pwm6_steer.sv
module pwm6_steer #(
  parameter int CNT_W     = 8,
  parameter int NUM_PAIRS = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic [CNT_W-1:0]       period_lim,
  input  logic [CNT_W-1:0]       cmp_val,
  input  logic                   slope_dual,
  input  logic [1:0]             out_mode,
  input  logic [2*NUM_PAIRS-1:0] pin_en,
  input  logic [2*NUM_PAIRS-1:0] port_val,
  output logic [2*NUM_PAIRS-1:0] pins,
  output logic                   ovf_flag,
  input  logic                   ovf_clr
);
  logic [CNT_W-1:0] cnt;
  logic             dir_up;
  logic             mode_act;
  logic             reload;
  logic             wave;

  pwm6_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period_lim(period_lim),
    .slope_dual(slope_dual), .cnt(cnt), .dir_up(dir_up),
    .mode_act(mode_act), .reload(reload)
  );

  pwm6_wave #(.CNT_W(CNT_W)) u_wave (
    .clk(clk), .rst_n(rst_n), .reload(reload), .cmp_val(cmp_val),
    .cnt(cnt), .dir_up(dir_up), .mode_act(mode_act),
    .out_mode(out_mode), .wave(wave)
  );

  pwm6_pinmux #(.NUM_PAIRS(NUM_PAIRS)) u_pinmux (
    .clk(clk), .rst_n(rst_n), .wave(wave), .out_mode(out_mode),
    .pin_en(pin_en), .port_val(port_val), .pins(pins)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (reload)  ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> ovf_flag);
  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !reload) |=> !ovf_flag);
  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

// File: tb/pwm6_steer_bench.sv
module pwm6_steer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] period_lim = '0;
  logic [7:0] cmp_val = '0;
  logic       slope_dual = 1'b0;
  logic [1:0] out_mode = 2'b00;
  logic [5:0] pin_en = '0;
  logic [5:0] port_val = '0;
  logic [5:0] pins;
  logic       ovf_flag;
  logic       ovf_clr = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm6_steer u_pwm6_steer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period_lim(period_lim),
    .cmp_val(cmp_val), .slope_dual(slope_dual), .out_mode(out_mode),
    .pin_en(pin_en), .port_val(port_val), .pins(pins),
    .ovf_flag(ovf_flag), .ovf_clr(ovf_clr)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_pins(int c, bit down, int cmpv, bit dual,
                                          logic [1:0] om, logic [5:0] en,
                                          logic [5:0] pv);
    logic [5:0] r;
    bit wv;
    wv = (c < cmpv) || (dual && down && c == cmpv);
    if (om == 2'b11) wv = !wv;
    for (int i = 0; i < 6; i++)
      r[i] = (om != 2'b00 && en[i]) ? ((i % 2 == 0) ? wv : !wv) : pv[i];
    return r;
  endfunction

  // position p ticks after the first reload -> count, direction, reload flag
  task automatic pos(int p, int lim, bit dual, output int c, output bit down,
                     output bit at0);
    int q;
    if (!dual) begin
      q = p % (lim + 1); c = q; down = 0;
    end else if (lim == 0) begin
      q = 0; c = 0; down = 0;
    end else begin
      q = p % (2 * lim);
      c = (q <= lim) ? q : 2 * lim - q;
      down = (q > lim);
    end
    at0 = (q == 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_cfg(int lim, int cmpv, bit dual, logic [1:0] om,
                         logic [5:0] en, logic [5:0] pv, int ncyc, bit alt);
    int ticks = 0;
    int c; bit down; bit at0; bit tk;
    period_lim = 8'(lim); cmp_val = 8'(cmpv); slope_dual = dual;
    out_mode = om; pin_en = en; port_val = pv; ovf_clr = 1'b1;
    do_reset();
    for (int n = 0; n < ncyc; n++) begin
      tk = alt ? (n % 2 == 0) : 1'b1;
      tick = tk;
      @(posedge clk); @(negedge clk);
      if (tk) ticks++;
      if (ticks > 0) begin
        pos(ticks - 1, lim, dual, c, down, at0);
        chk(dual ? "R2 R6 R7 R8 R9" : "R1 R5 R7 R8 R9", alt ? "pins(R3)" : "pins",
            int'(pins), int'(exp_pins(c, down, cmpv, dual, om, en, pv)));
        chk("R4", "flag", int'(ovf_flag), int'(tk && at0));
      end
    end
    tick = 1'b0;
  endtask

  initial begin
    int idx = 0;
    int lims_s[5] = '{0, 1, 2, 3, 5};
    int lims_d[4] = '{1, 2, 3, 5};
    logic [1:0] oms[3] = '{2'b01, 2'b10, 2'b11};
    logic [5:0] en, pv;

    // reset state
    out_mode = 2'b10; pin_en = 6'b111111; port_val = 6'b000000;
    do_reset();
    chk("R8", "reset pins", int'(pins), int'(6'b101010));
    chk("R4", "reset flag", int'(ovf_flag), 0);

    // sawtooth and triangle sweeps
    for (int d = 0; d < 2; d++) begin
      for (int li = 0; li < (d ? 4 : 5); li++) begin
        int lim = d ? lims_d[li] : lims_s[li];
        int per = d ? 2 * lim : lim + 1;
        for (int cv = 0; cv <= lim + 1; cv++) begin
          for (int m = 0; m < 3; m++) begin
            en = (idx % 4 == 3) ? 6'b101101 : 6'b111111;
            pv = 6'(idx) ^ 6'b010110;
            run_cfg(lim, cv, d[0], oms[m], en, pv, 2 * per + 3, 1'b0);
            idx++;
          end
        end
      end
    end

    // R3: ticks on alternate cycles only
    run_cfg(3, 2, 1'b0, 2'b10, 6'b111111, 6'b0, 20, 1'b1);
    run_cfg(3, 2, 1'b1, 2'b11, 6'b111111, 6'b0, 24, 1'b1);

    // R7/R9: disconnected mode shows port values regardless of enables
    run_cfg(4, 2, 1'b0, 2'b00, 6'b111111, 6'b100110, 8, 1'b0);
    run_cfg(4, 2, 1'b1, 2'b00, 6'b010101, 6'b011001, 10, 1'b0);

    // R4: sticky flag, clear, and set-beats-clear
    period_lim = 8'd3; cmp_val = 8'd2; slope_dual = 1'b0; out_mode = 2'b10;
    pin_en = 6'b111111; ovf_clr = 1'b0;
    do_reset();
    tick = 1'b1; @(posedge clk); @(negedge clk);
    chk("R4", "flag first reload", int'(ovf_flag), 1);
    tick = 1'b0;
    for (int n = 0; n < 3; n++) begin
      @(posedge clk); @(negedge clk);
      chk("R4", "flag sticky", int'(ovf_flag), 1);
      chk("R3", "pins idle", int'(pins), int'(6'b010101));
    end
    ovf_clr = 1'b1; @(posedge clk); @(negedge clk);
    chk("R4", "flag cleared", int'(ovf_flag), 0);
    ovf_clr = 1'b0; tick = 1'b1;
    for (int n = 0; n < 3; n++) begin
      @(posedge clk); @(negedge clk);
      chk("R4", "flag no reload", int'(ovf_flag), 0);
    end
    ovf_clr = 1'b1; @(posedge clk); @(negedge clk);
    chk("R4", "set beats clear", int'(ovf_flag), 1);
    tick = 1'b0;

    // R10: mid-period writes wait for the reload
    period_lim = 8'd7; cmp_val = 8'd3; slope_dual = 1'b0; out_mode = 2'b10;
    pin_en = 6'b111111; port_val = 6'b0; ovf_clr = 1'b1;
    do_reset();
    tick = 1'b1;
    for (int p = 0; p < 24; p++) begin
      int c; bit down; bit at0; int cv; bit dl;
      @(posedge clk); @(negedge clk);
      if (p < 8) begin
        c = p; down = 0; at0 = (p == 0); cv = 3; dl = 0;
      end else begin
        pos(p - 8, 4, 1'b1, c, down, at0); cv = 2; dl = 1;
      end
      chk("R10", "pins", int'(pins), int'(exp_pins(c, down, cv, dl, 2'b10, 6'h3f, 6'h0)));
      chk("R10", "flag", int'(ovf_flag), int'(at0));
      if (p == 2) begin
        period_lim = 8'd4; cmp_val = 8'd2; slope_dual = 1'b1;
      end
    end
    tick = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule